// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. It holds an 8-bit accumulator and a five-bit set of condition flags (sign, zero, half carry, parity, carry). Each cycle in which the strobe is high, it applies one operation selected by a 5-bit code to the accumulator and to an 8-bit operand. The new accumulator and the new flags are visible one clock later. Instruction fetch, decode and memory traffic belong to the surrounding core. This block sees only the operation code and the data.

Each class of operation updates a different subset of the flags. Arithmetic updates all five flags. Logic operations force the carry and the half carry to fixed values. Increment and decrement keep the carry. Rotates and the flag-only operations touch the carry alone. A separate 16-bit pair adder shares the carry flag and affects no other flag.

A combinational condition output evaluates one of eight flag tests against the registered flags, for branch decisions.

Top module: `accu_alu_top`

## Requirements
- R1: While reset is applied, and after it is released until the first strobed operation, the accumulator reads 0x00, the flag byte reads 0x02 and the pair sum reads 0x0000.
- R2: The flag byte places sign in bit 7, zero in bit 6, half carry in bit 4, parity in bit 2 and carry in bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0. Sign is bit 7 of the result. Zero is set when the result is 0x00. Parity is set when the result has an even number of ones.
- R3: Add (code 0) and add-with-carry (code 1) compute A + operand (+ CY for code 1). CY is the carry out of bit 7 and AC is the carry out of bit 3. S, Z and P follow the result.
- R4: Subtract (code 2), subtract-with-borrow (code 3, borrow = CY) and compare (code 7) compute A - operand - borrow. CY is set when the true difference is negative. AC is set when A[3:0] >= operand[3:0] + borrow. S, Z and P follow the difference. Compare leaves the accumulator unchanged.
- R5: AND (code 4) sets AC and clears CY. XOR (code 5) and OR (code 6) clear both AC and CY. All three set S, Z and P from the result.
- R6: Increment (code 8) and decrement (code 9) keep CY. Increment sets AC when A[3:0] was 0xF. Decrement sets AC when A[3:0] was not 0x0. S, Z and P follow the result.
- R7: Complement (code 10) inverts A and changes no flag. Set-carry (code 15) forces CY to 1. Complement-carry (code 16) inverts CY. Neither of these two changes A or any other flag.
- R8: Rotate left (code 11) and rotate right (code 12) copy the bit that leaves A into both the opposite end and CY. Rotate left through carry (code 13) and rotate right through carry (code 14) move the leaving bit into CY and the old CY into the opposite end. Rotates change no flag other than CY.
- R9: Decimal adjust (code 17) adds 0x06 when A[3:0] > 9 or AC is set, and adds 0x60 when A > 0x99 or CY is set. The A > 0x99 test uses the original A. CY becomes the old CY OR (A > 0x99). AC is the carry out of bit 3 of that addition. S, Z and P follow the result.
- R10: Pair add (code 18) registers pair_a + pair_b (mod 2^16) on pair_sum and sets CY to the carry out of bit 15. The accumulator and the other flags are unchanged.
- R11: cond_true is combinational from the registered flags. Select 0 = not zero, 1 = zero, 2 = no carry, 3 = carry, 4 = parity odd, 5 = parity even, 6 = plus (S clear), 7 = minus (S set).
- R12: Without the strobe, or with a code of 19 to 31, the accumulator, the flags and the pair sum keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Strobe: apply op_code this cycle |
| op_code | input | 5 | Operation select |
| operand | input | 8 | Second ALU operand |
| pair_a | input | 16 | First 16-bit addend for pair add |
| pair_b | input | 16 | Second 16-bit addend for pair add |
| cond_sel | input | 3 | Condition test select |
| acc | output | 8 | Accumulator |
| flags | output | 8 | Packed flag byte |
| pair_sum | output | 16 | Registered result of the last pair add |
| cond_true | output | 1 | Result of the selected condition test |

## Verification
A wrong flag write-enable for one class of operation corrupts a flag that should have been kept. The error appears on the flag byte in the cycle after that operation, but it often surfaces only later, through the condition output or through a following ADC, SBB, rotate-through-carry or decimal adjust that consumes the stale carry or half carry. The bench therefore keeps a running reference state and compares the accumulator, the whole flag byte and one condition test after every operation. A chain of dependent operations then exposes a corrupted flag within a single step. Decimal adjust and the pair add get directed cases, because they depend on flag state that ordinary arithmetic rarely leaves behind.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;

  localparam int DATA_W = 8;
  localparam int PAIR_W = 2 * DATA_W;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_AND  = 5'd4,
    OP_XOR  = 5'd5,
    OP_OR   = 5'd6,
    OP_CMP  = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_CPL  = 5'd10,
    OP_ROL  = 5'd11,
    OP_ROR  = 5'd12,
    OP_RCL  = 5'd13,
    OP_RCR  = 5'd14,
    OP_SETC = 5'd15,
    OP_INVC = 5'd16,
    OP_DADJ = 5'd17,
    OP_PADD = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  localparam flags_t FLAGS_RESET = '0;

  function automatic logic [DATA_W-1:0] pack_flags(flags_t f);
    return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
  endfunction

endpackage

// File: rtl/accu_rst_sync.sv
module accu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/accu_alu_core.sv
module accu_alu_core
  import accu_alu_pkg::*;
(
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] acc_cur,
  input  flags_t            flg_cur,
  input  logic [DATA_W-1:0] operand,
  input  logic [PAIR_W-1:0] pair_a,
  input  logic [PAIR_W-1:0] pair_b,
  output logic [DATA_W-1:0] acc_nxt,
  output flags_t            flg_nxt,
  output logic              acc_we,
  output logic              flg_we,
  output logic              pair_we,
  output logic [PAIR_W-1:0] pair_nxt
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] add_b;
  logic              add_cin;
  logic [HALF_W:0]   lo_sum;
  logic [DATA_W:0]   full_sum;
  logic [PAIR_W:0]   pair_full;
  logic              borrow_in;
  logic              lo_fix, hi_fix;
  logic [DATA_W-1:0] res;
  logic              upd_szp;

  assign borrow_in = (op == OP_SBB) ? flg_cur.cy : 1'b0;
  assign lo_fix    = flg_cur.ac || (acc_cur[HALF_W-1:0] > 4'd9);
  assign hi_fix    = flg_cur.cy || (acc_cur > 8'h99);

  // Shared 8-bit adder operand select
  always_comb begin
    add_b   = operand;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC:                 add_cin = flg_cur.cy;
      OP_SUB, OP_SBB, OP_CMP: begin
        add_b   = ~operand;
        add_cin = ~borrow_in;
      end
      OP_INC:  add_b = 8'h01;
      OP_DEC:  add_b = 8'hFF;
      OP_DADJ: add_b = {hi_fix ? 4'h6 : 4'h0, lo_fix ? 4'h6 : 4'h0};
      default: ;
    endcase
  end

  assign lo_sum    = {1'b0, acc_cur[HALF_W-1:0]} + {1'b0, add_b[HALF_W-1:0]} + {{HALF_W{1'b0}}, add_cin};
  assign full_sum  = {1'b0, acc_cur} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_cin};
  assign pair_full = {1'b0, pair_a} + {1'b0, pair_b};
  assign pair_nxt  = pair_full[PAIR_W-1:0];

  // Result and flag selection
  always_comb begin
    res     = acc_cur;
    flg_nxt = flg_cur;
    acc_we  = 1'b0;
    flg_we  = 1'b1;
    pair_we = 1'b0;
    upd_szp = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res = full_sum[DATA_W-1:0]; acc_we = 1'b1; upd_szp = 1'b1;
        flg_nxt.cy = full_sum[DATA_W]; flg_nxt.ac = lo_sum[HALF_W];
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        res = full_sum[DATA_W-1:0]; acc_we = (op != OP_CMP); upd_szp = 1'b1;
        flg_nxt.cy = ~full_sum[DATA_W]; flg_nxt.ac = lo_sum[HALF_W];
      end
      OP_AND: begin
        res = acc_cur & operand; acc_we = 1'b1; upd_szp = 1'b1;
        flg_nxt.cy = 1'b0; flg_nxt.ac = 1'b1;
      end
      OP_XOR, OP_OR: begin
        res = (op == OP_XOR) ? (acc_cur ^ operand) : (acc_cur | operand);
        acc_we = 1'b1; upd_szp = 1'b1;
        flg_nxt.cy = 1'b0; flg_nxt.ac = 1'b0;
      end
      OP_INC, OP_DEC: begin
        res = full_sum[DATA_W-1:0]; acc_we = 1'b1; upd_szp = 1'b1;
        flg_nxt.ac = lo_sum[HALF_W];
      end
      OP_CPL: begin
        res = ~acc_cur; acc_we = 1'b1; flg_we = 1'b0;
      end
      OP_ROL: begin
        res = {acc_cur[DATA_W-2:0], acc_cur[DATA_W-1]}; acc_we = 1'b1;
        flg_nxt.cy = acc_cur[DATA_W-1];
      end
      OP_ROR: begin
        res = {acc_cur[0], acc_cur[DATA_W-1:1]}; acc_we = 1'b1;
        flg_nxt.cy = acc_cur[0];
      end
      OP_RCL: begin
        res = {acc_cur[DATA_W-2:0], flg_cur.cy}; acc_we = 1'b1;
        flg_nxt.cy = acc_cur[DATA_W-1];
      end
      OP_RCR: begin
        res = {flg_cur.cy, acc_cur[DATA_W-1:1]}; acc_we = 1'b1;
        flg_nxt.cy = acc_cur[0];
      end
      OP_SETC: flg_nxt.cy = 1'b1;
      OP_INVC: flg_nxt.cy = ~flg_cur.cy;
      OP_DADJ: begin
        res = full_sum[DATA_W-1:0]; acc_we = 1'b1; upd_szp = 1'b1;
        flg_nxt.cy = hi_fix; flg_nxt.ac = lo_sum[HALF_W];
      end
      OP_PADD: begin
        pair_we = 1'b1; flg_nxt.cy = pair_full[PAIR_W];
      end
      default: flg_we = 1'b0;
    endcase
    if (upd_szp) begin
      flg_nxt.s = res[DATA_W-1];
      flg_nxt.z = (res == '0);
      flg_nxt.p = ~^res;
    end
    acc_nxt = res;
  end
endmodule

// File: rtl/accu_cond_eval.sv
module accu_cond_eval
  import accu_alu_pkg::*;
(
  input  flags_t     flg,
  input  logic [2:0] sel,
  output logic       hit
);
  logic tested;

  always_comb begin
    unique case (sel[2:1])
      2'd0:    tested = flg.z;
      2'd1:    tested = flg.cy;
      2'd2:    tested = flg.p;
      default: tested = flg.s;
    endcase
  end

  // Odd select asks for the flag set, even select for it clear
  assign hit = sel[0] ? tested : ~tested;
endmodule

// File: rtl/accu_alu_top.sv
module accu_alu_top
  import accu_alu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic [PAIR_W-1:0] pair_a,
  input  logic [PAIR_W-1:0] pair_b,
  input  logic [2:0]        cond_sel,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] flags,
  output logic [PAIR_W-1:0] pair_sum,
  output logic              cond_true
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] acc_q, acc_d;
  flags_t            flg_q, flg_d;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic              acc_we, flg_we, pair_we;
  logic              acc_en, flg_en, pair_en;

  accu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  accu_alu_core u_core (
    .op      (op_code),
    .acc_cur (acc_q),
    .flg_cur (flg_q),
    .operand (operand),
    .pair_a  (pair_a),
    .pair_b  (pair_b),
    .acc_nxt (acc_d),
    .flg_nxt (flg_d),
    .acc_we  (acc_we),
    .flg_we  (flg_we),
    .pair_we (pair_we),
    .pair_nxt(pair_d)
  );

  accu_cond_eval u_cond (
    .flg (flg_q),
    .sel (cond_sel),
    .hit (cond_true)
  );

  assign acc_en  = op_valid && acc_we;
  assign flg_en  = op_valid && flg_we;
  assign pair_en = op_valid && pair_we;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q  <= '0;
      flg_q  <= FLAGS_RESET;
      pair_q <= '0;
    end else begin
      if (acc_en)  acc_q  <= acc_d;
      if (flg_en)  flg_q  <= flg_d;
      if (pair_en) pair_q <= pair_d;
    end
  end

  assign acc      = acc_q;
  assign flags    = pack_flags(flg_q);
  assign pair_sum = pair_q;

  assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_CMP) |=> acc_q == $past(acc_q));

  assert_and_flags_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_AND) |=> (flg_q.ac && !flg_q.cy));

  assert_incdec_keeps_cy_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> flg_q.cy == $past(flg_q.cy));

  assert_cpl_no_flags_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_CPL) |=> (flg_q == $past(flg_q) && acc_q == ~$past(acc_q)));

  assert_rotate_only_cy_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code >= OP_ROL && op_code <= OP_RCR)
      |=> {flg_q.s, flg_q.z, flg_q.ac, flg_q.p} == $past({flg_q.s, flg_q.z, flg_q.ac, flg_q.p}));

  assert_pair_only_cy_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OP_PADD)
      |=> (acc_q == $past(acc_q) && {flg_q.s, flg_q.z, flg_q.ac, flg_q.p} == $past({flg_q.s, flg_q.z, flg_q.ac, flg_q.p})));

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_valid || op_code > OP_PADD) |=> ($stable(acc_q) && $stable(flg_q) && $stable(pair_q)));
endmodule

// File: tb/accu_alu_top_bench.sv
`timescale 1ns/1ps
module accu_alu_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_code;
  logic [7:0]  operand;
  logic [15:0] pair_a, pair_b;
  logic [2:0]  cond_sel;
  logic [7:0]  acc, flags;
  logic [15:0] pair_sum;
  logic        cond_true;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference state: s z ac p cy
  int m_acc;
  bit m_s, m_z, m_ac, m_p, m_cy;
  int m_pair;

  always #5 clk = ~clk;

  accu_alu_top u_accu_alu_top (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .pair_a(pair_a), .pair_b(pair_b), .cond_sel(cond_sel),
    .acc(acc), .flags(flags), .pair_sum(pair_sum), .cond_true(cond_true)
  );

  // entries: {op[4:0], operand[7:0]}
  localparam int NV = 34;
  localparam logic [12:0] VEC [0:NV-1] = '{
    {5'd6, 8'h3A}, {5'd0, 8'hC6}, {5'd1, 8'h0F}, {5'd0, 8'h7F}, {5'd2, 8'h10},
    {5'd3, 8'hF0}, {5'd3, 8'h01}, {5'd7, 8'h02}, {5'd7, 8'h00}, {5'd4, 8'h0F},
    {5'd5, 8'hFF}, {5'd6, 8'h81}, {5'd8, 8'h00}, {5'd9, 8'h00}, {5'd10, 8'h00},
    {5'd11, 8'h00}, {5'd12, 8'h00}, {5'd13, 8'h00}, {5'd14, 8'h00}, {5'd15, 8'h00},
    {5'd16, 8'h00}, {5'd16, 8'h00}, {5'd14, 8'h00}, {5'd4, 8'h00}, {5'd9, 8'h00},
    {5'd8, 8'h00}, {5'd0, 8'h38}, {5'd1, 8'h29}, {5'd17, 8'h00}, {5'd22, 8'hAA},
    {5'd31, 8'h55}, {5'd18, 8'h00}, {5'd2, 8'h62}, {5'd17, 8'h00}
  };

  function automatic bit even_ones(int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return (c % 2) == 0;
  endfunction

  task automatic set_szp(int r);
    m_s = r[7]; m_z = (r == 0); m_p = even_ones(r);
  endtask

  task automatic model_step(int op, int b);
    int a = m_acc;
    int t, br, lo, hi;
    case (op)
      0, 1: begin
        br = (op == 1) ? int'(m_cy) : 0;
        t = a + b + br; m_ac = ((a & 15) + (b & 15) + br) > 15;
        m_cy = t > 255; t &= 255; set_szp(t); m_acc = t;
      end
      2, 3, 7: begin
        br = (op == 3) ? int'(m_cy) : 0;
        t = a - b - br; m_cy = t < 0; m_ac = (a & 15) >= ((b & 15) + br);
        t &= 255; set_szp(t); if (op != 7) m_acc = t;
      end
      4: begin m_acc = a & b; set_szp(m_acc); m_cy = 0; m_ac = 1; end
      5: begin m_acc = a ^ b; set_szp(m_acc); m_cy = 0; m_ac = 0; end
      6: begin m_acc = a | b; set_szp(m_acc); m_cy = 0; m_ac = 0; end
      8: begin m_ac = (a & 15) == 15; m_acc = (a + 1) & 255; set_szp(m_acc); end
      9: begin m_ac = (a & 15) != 0; m_acc = (a + 255) & 255; set_szp(m_acc); end
      10: m_acc = (~a) & 255;
      11: begin m_cy = a[7]; m_acc = ((a << 1) | (a >> 7)) & 255; end
      12: begin m_cy = a[0]; m_acc = ((a >> 1) | (a << 7)) & 255; end
      13: begin t = m_cy; m_cy = a[7]; m_acc = ((a << 1) | t) & 255; end
      14: begin t = m_cy; m_cy = a[0]; m_acc = ((a >> 1) | (t << 7)) & 255; end
      15: m_cy = 1;
      16: m_cy = !m_cy;
      17: begin
        lo = (m_ac || (a & 15) > 9) ? 6 : 0;
        hi = (m_cy || a > 'h99) ? 'h60 : 0;
        m_ac = ((a & 15) + lo) > 15;
        m_cy = m_cy || (a > 'h99);
        m_acc = (a + lo + hi) & 255; set_szp(m_acc);
      end
      18: begin t = int'(pair_a) + int'(pair_b); m_cy = t > 'hFFFF; m_pair = t & 'hFFFF; end
      default: ;
    endcase
  endtask

  function automatic int model_flags();
    return (int'(m_s) << 7) | (int'(m_z) << 6) | (int'(m_ac) << 4) | (int'(m_p) << 2) | 2 | int'(m_cy);
  endfunction

  function automatic bit model_cond(int sel);
    bit f;
    case (sel / 2)
      0: f = m_z;
      1: f = m_cy;
      2: f = m_p;
      default: f = m_s;
    endcase
    return (sel % 2) ? f : !f;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(int op, int b, int sel);
    @(negedge clk);
    op_valid = 1'b1; op_code = op[4:0]; operand = b[7:0];
    @(negedge clk);
    op_valid = 1'b0; cond_sel = sel[2:0];
    model_step(op, b);
    #1;
  endtask

  task automatic check_all(string req, int sel);
    chk(req, "acc", int'(acc), m_acc);
    chk(req, "flags", int'(flags), model_flags());
    chk("R11", "cond", int'(cond_true), int'(model_cond(sel)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; operand = '0;
    pair_a = '0; pair_b = '0; cond_sel = '0;
    m_acc = 0; {m_s, m_z, m_ac, m_p, m_cy} = '0; m_pair = 0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", "acc in reset", int'(acc), 0);
    chk("R1", "flags in reset", int'(flags), 'h02);
    chk("R1", "pair in reset", int'(pair_sum), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "acc after release", int'(acc), 0);
    chk("R2", "flags after release", int'(flags), 'h02);

    // R12: strobe low, operation presented but not applied
    op_code = 5'd0; operand = 8'h55;
    repeat (2) @(negedge clk);
    chk("R12", "acc no strobe", int'(acc), 0);
    chk("R12", "flags no strobe", int'(flags), 'h02);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      int op = int'(VEC[i][12:8]);
      do_op(op, int'(VEC[i][7:0]), i % 8);
      case (op)
        0, 1:          check_all("R3", i % 8);
        2, 3, 7:       check_all("R4", i % 8);
        4, 5, 6:       check_all("R5", i % 8);
        8, 9:          check_all("R6", i % 8);
        10, 15, 16:    check_all("R7", i % 8);
        11, 12, 13, 14: check_all("R8", i % 8);
        17:            check_all("R9", i % 8);
        18:            check_all("R10", i % 8);
        default:       check_all("R12", i % 8);
      endcase
    end

    // R9: directed decimal adjust of 0x9B with AC=CY=0
    do_op(4, 0, 0);
    do_op(6, 'h9B, 0);
    do_op(17, 0, 3);
    chk("R9", "daa acc", int'(acc), 'h01);
    chk("R9", "daa flags", int'(flags), 'h13);
    chk("R11", "carry test", int'(cond_true), 1);

    // R10: pair add overflow, other flags kept
    pair_a = 16'hFFFF; pair_b = 16'h0001;
    do_op(18, 0, 3);
    chk("R10", "pair sum wrap", int'(pair_sum), 0);
    chk("R10", "pair flags", int'(flags), 'h13);
    pair_a = 16'h1234; pair_b = 16'h1111;
    do_op(18, 0, 2);
    chk("R10", "pair sum", int'(pair_sum), 'h2345);
    chk("R10", "pair flags no carry", int'(flags), 'h12);
    chk("R11", "no carry test", int'(cond_true), 1);

    // R12: unassigned code keeps pair sum too
    do_op(25, 'hFF, 0);
    chk("R12", "pair kept", int'(pair_sum), 'h2345);
    check_all("R12", 0);

    // R6: increment of 0xFF wraps with CY kept set
    do_op(15, 0, 0);
    do_op(4, 0, 0);
    do_op(6, 'hFF, 0);
    do_op(15, 0, 0);
    do_op(8, 0, 1);
    chk("R6", "inc wrap acc", int'(acc), 0);
    chk("R6", "inc wrap flags", int'(flags), 'h57);
    chk("R11", "zero test", int'(cond_true), 1);

    finish_run();
  end
endmodule